// File: doc/BRIEF.md
# Counter CSR Access Gate

This block sits in front of a hart's shared 64-bit event counter and the performance-counter register space. Each cycle it takes one CSR address and the current privilege level and returns, combinationally, a read-data word and a flag saying whether that access is allowed. The same counter serves both the cycle and the retired-instruction names. The unimplemented performance counters and event selectors read as zero. Reads of the user-level aliases are gated by a counter-enable mask, and that mask is chosen by privilege.

Writes land on the clock edge. With a 32-bit register width, the counter is written one half at a time through a low and a high register. With a 64-bit width, the low register writes the whole counter. A retire strobe advances the counter. The block does not raise traps. A caller that sees the permit flag low decides what to do.

Top module: `ctr_gate`

## Requirements
- R1: The read mask comes from privilege. Privilege 2'b00 (user) uses the user enable register. Privilege 2'b01 (supervisor) uses the supervisor enable register. Any other value (2'b11 machine) uses all ones, so every user alias is permitted.
- R2: For a user alias (0xC00–0xC1F, and 0xC83–0xC9F when XLEN is 32), permit is the mask bit selected by address bits [4:0]. Whenever permit is low, the read data is zero.
- R3: A permitted read of 0xC00 or 0xC02 returns the low XLEN bits of the shared counter. 0xB00 and 0xB02 always return them with permit high. 0xC01, 0x322 and addresses outside the block's space give permit low and data zero.
- R4: A permitted read of 0xC03–0xC1F returns zero. When XLEN is 32, 0xC83–0xC9F also return zero when permitted.
- R5: 0xB03–0xB1F and 0x323–0x33F always read zero with permit high. When XLEN is 32, 0xB83–0xB9F do the same.
- R6: When XLEN is 32, a write to 0xB00 or 0xB02 replaces counter bits 31:0 and keeps bits 63:32. A write to 0xB80 or 0xB82 replaces bits 63:32 and keeps bits 31:0. Reads of 0xB80 and 0xB82 return bits 63:32.
- R7: When XLEN is 64, a write to 0xB00 or 0xB02 replaces the whole counter. 0xB80 and 0xB82 are outside the block: reads give permit low and data zero, and writes are ignored.
- R8: The user enable register sits at 0x320 and the supervisor enable register at 0x321. Each stores the full written XLEN-bit value with no masking. Both read back with permit high at any privilege.
- R9: Each cycle that retire is high, the counter rises by one, and the carry runs across both halves. A counter write in the same cycle wins, and no increment is applied.
- R10: After reset, the counter and both enable registers are zero.
- R11: Writes to the user aliases and to the zero ranges leave the counter and the enable registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| csr_addr_i | input | 12 | CSR address of this cycle's access |
| csr_wr_i | input | 1 | Write strobe for csr_addr_i |
| csr_wdata_i | input | XLEN | Write data |
| retire_i | input | 1 | Instruction-retired strobe, adds one to the counter |
| rdata_o | output | XLEN | Read data for csr_addr_i |
| permit_o | output | 1 | Access to csr_addr_i is allowed |

## Verification
The checker assumes that every input is a known value on each clock edge and that each cycle carries at most one access. The privilege assertions are written for the three defined encodings. The stimulus drives inputs only between clock edges and uses only user, supervisor and machine privilege. It holds retire low during every read it scores, so the counter cannot move under a read. The 64-bit variant runs as a second instance on its own input signals, so the two widths never share a cycle's stimulus.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;

   localparam int CNT_W     = 64;
   localparam int HPM_FIRST = 3;

   localparam logic [1:0] PRV_USER  = 2'b00;
   localparam logic [1:0] PRV_SUPER = 2'b01;

   // address pages: bits [11:5] of the CSR address
   localparam logic [6:0] PG_USER_LO = 7'b1100_000;   // 0xC00-0xC1F
   localparam logic [6:0] PG_USER_HI = 7'b1100_100;   // 0xC80-0xC9F
   localparam logic [6:0] PG_MACH_LO = 7'b1011_000;   // 0xB00-0xB1F
   localparam logic [6:0] PG_MACH_HI = 7'b1011_100;   // 0xB80-0xB9F
   localparam logic [6:0] PG_EVENT   = 7'b0011_001;   // 0x320-0x33F

   localparam logic [4:0] IDX_CYC   = 5'd0;
   localparam logic [4:0] IDX_RET   = 5'd2;
   localparam logic [4:0] IDX_UEN   = 5'd0;
   localparam logic [4:0] IDX_SEN   = 5'd1;

   typedef enum logic [2:0] {
      AC_NONE,
      AC_UCNT,
      AC_UHPM,
      AC_MCNT_LO,
      AC_MCNT_HI,
      AC_MZERO,
      AC_UEN,
      AC_SEN
   } acc_class_e;

endpackage

// File: rtl/ctr_gate_decode.sv
module ctr_gate_decode
   import ctr_gate_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [11:0] addr_i,
   output acc_class_e  cls_o
);

   localparam bit HAS_HI = (XLEN == 32);

   logic [6:0] page;
   logic [4:0] idx;
   logic       is_cnt;
   logic       is_hpm;

   assign page   = addr_i[11:5];
   assign idx    = addr_i[4:0];
   assign is_cnt = (idx == IDX_CYC) || (idx == IDX_RET);
   assign is_hpm = (32'(idx) >= HPM_FIRST);

   always_comb begin
      cls_o = AC_NONE;
      unique case (page)
         PG_USER_LO: begin
            if (is_cnt)      cls_o = AC_UCNT;
            else if (is_hpm) cls_o = AC_UHPM;
         end
         PG_USER_HI: begin
            if (HAS_HI && is_hpm) cls_o = AC_UHPM;
         end
         PG_MACH_LO: begin
            if (is_cnt)      cls_o = AC_MCNT_LO;
            else if (is_hpm) cls_o = AC_MZERO;
         end
         PG_MACH_HI: begin
            if (HAS_HI && is_cnt)      cls_o = AC_MCNT_HI;
            else if (HAS_HI && is_hpm) cls_o = AC_MZERO;
         end
         PG_EVENT: begin
            if (idx == IDX_UEN)      cls_o = AC_UEN;
            else if (idx == IDX_SEN) cls_o = AC_SEN;
            else if (is_hpm)         cls_o = AC_MZERO;
         end
         default: cls_o = AC_NONE;
      endcase
   end

endmodule

// File: rtl/ctr_gate_counter.sv
module ctr_gate_counter
   import ctr_gate_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo_i,
   input  logic             wr_hi_i,
   input  logic [XLEN-1:0]  wdata_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int UPPER = CNT_W - XLEN;

   logic [CNT_W-1:0] cnt_q;

   generate
      if (UPPER > 0) begin : g_split
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (wr_lo_i) cnt_q <= {cnt_q[CNT_W-1:XLEN], wdata_i};
            else if (wr_hi_i) cnt_q <= {wdata_i[UPPER-1:0], cnt_q[XLEN-1:0]};
            else if (inc_i)   cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_full
         logic unused_hi;
         assign unused_hi = wr_hi_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (wr_lo_i) cnt_q <= CNT_W'(wdata_i);
            else if (inc_i)   cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   assign cnt_o = cnt_q;

endmodule

// File: rtl/ctr_gate_enables.sv
module ctr_gate_enables
   import ctr_gate_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_u_i,
   input  logic            wr_s_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic [1:0]      priv_i,
   output logic [XLEN-1:0] uen_o,
   output logic [XLEN-1:0] sen_o,
   output logic [XLEN-1:0] mask_o
);

   logic [XLEN-1:0] uen_q;
   logic [XLEN-1:0] sen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uen_q <= '0;
         sen_q <= '0;
      end else begin
         if (wr_u_i) uen_q <= wdata_i;
         if (wr_s_i) sen_q <= wdata_i;
      end
   end

   always_comb begin
      unique case (priv_i)
         PRV_USER:  mask_o = uen_q;
         PRV_SUPER: mask_o = sen_q;
         default:   mask_o = '1;
      endcase
   end

   assign uen_o = uen_q;
   assign sen_o = sen_q;

endmodule

// File: rtl/ctr_gate.sv
module ctr_gate
   import ctr_gate_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      priv_i,
   input  logic [11:0]     csr_addr_i,
   input  logic            csr_wr_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   input  logic            retire_i,
   output logic [XLEN-1:0] rdata_o,
   output logic            permit_o
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("ctr_gate: XLEN must be 32 or 64");
      end
      if (CNT_W < XLEN) begin : g_bad_cnt
         $error("ctr_gate: counter narrower than XLEN");
      end
   endgenerate

   acc_class_e       cls;
   logic [4:0]       idx;
   logic [CNT_W-1:0] cnt_q;
   logic [XLEN-1:0]  uen_q;
   logic [XLEN-1:0]  sen_q;
   logic [XLEN-1:0]  mask;
   logic             wr_lo, wr_hi, wr_u, wr_s;

   assign idx = csr_addr_i[4:0];

   ctr_gate_decode #(.XLEN(XLEN)) u_dec (
      .addr_i (csr_addr_i),
      .cls_o  (cls)
   );

   assign wr_lo = csr_wr_i && (cls == AC_MCNT_LO);
   assign wr_hi = csr_wr_i && (cls == AC_MCNT_HI);
   assign wr_u  = csr_wr_i && (cls == AC_UEN);
   assign wr_s  = csr_wr_i && (cls == AC_SEN);

   ctr_gate_counter #(.XLEN(XLEN)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo_i (wr_lo),
      .wr_hi_i (wr_hi),
      .wdata_i (csr_wdata_i),
      .inc_i   (retire_i),
      .cnt_o   (cnt_q)
   );

   ctr_gate_enables #(.XLEN(XLEN)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_u_i  (wr_u),
      .wr_s_i  (wr_s),
      .wdata_i (csr_wdata_i),
      .priv_i  (priv_i),
      .uen_o   (uen_q),
      .sen_o   (sen_q),
      .mask_o  (mask)
   );

   always_comb begin
      unique case (cls)
         AC_NONE:          permit_o = 1'b0;
         AC_UCNT, AC_UHPM: permit_o = mask[idx];
         default:          permit_o = 1'b1;
      endcase
   end

   always_comb begin
      rdata_o = '0;
      if (permit_o) begin
         unique case (cls)
            AC_UCNT, AC_MCNT_LO: rdata_o = cnt_q[XLEN-1:0];
            AC_MCNT_HI:          rdata_o = cnt_q[CNT_W-1:CNT_W-XLEN];
            AC_UEN:              rdata_o = uen_q;
            AC_SEN:              rdata_o = sen_q;
            default:             rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/ctr_gate_chk.sv
module ctr_gate_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      priv_i,
   input logic [11:0]     csr_addr_i,
   input logic            csr_wr_i,
   input logic [XLEN-1:0] csr_wdata_i,
   input logic            retire_i,
   input logic [XLEN-1:0] rdata_o,
   input logic            permit_o,
   input logic [63:0]     cnt_q,
   input logic [XLEN-1:0] uen_q,
   input logic [XLEN-1:0] sen_q
);

   logic lo_addr, hi_addr, cnt_wr;
   assign lo_addr = (csr_addr_i == 12'hB00) || (csr_addr_i == 12'hB02);
   assign hi_addr = (csr_addr_i == 12'hB80) || (csr_addr_i == 12'hB82);
   assign cnt_wr  = csr_wr_i && (lo_addr || (XLEN == 32 && hi_addr));

   // R2
   user_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_i == 2'b00 && csr_addr_i[11:5] == 7'h60 && permit_o) |-> uen_q[csr_addr_i[4:0]]);

   // R1
   super_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_i == 2'b01 && csr_addr_i[11:5] == 7'h60 && permit_o) |-> sen_q[csr_addr_i[4:0]]);

   // R2
   denied_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !permit_o |-> (rdata_o == '0));

   // R3
   mach_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_addr |-> (permit_o && rdata_o == cnt_q[XLEN-1:0]));

   // R5
   mach_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr_i[11:5] == 7'h58 && csr_addr_i[4:0] >= 5'd3) |-> (permit_o && rdata_o == '0));

   // R6
   low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (XLEN == 32 && csr_wr_i && lo_addr) |=>
         (cnt_q[63:32] == $past(cnt_q[63:32]) && cnt_q[31:0] == $past(csr_wdata_i[31:0])));

   // R8
   uen_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_i && csr_addr_i == 12'h320) |=> (uen_q == $past(csr_wdata_i)));

   // R9
   retire_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 64'd1));

endmodule

bind ctr_gate ctr_gate_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .priv_i      (priv_i),
   .csr_addr_i  (csr_addr_i),
   .csr_wr_i    (csr_wr_i),
   .csr_wdata_i (csr_wdata_i),
   .retire_i    (retire_i),
   .rdata_o     (rdata_o),
   .permit_o    (permit_o),
   .cnt_q       (cnt_q),
   .uen_q       (uen_q),
   .sen_q       (sen_q)
);

// File: tb/tb_ctr_gate.sv
`timescale 1ns/1ps
module tb_ctr_gate;

   localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;

   logic [1:0]  priv32 = M;
   logic [11:0] addr32 = 12'h000;
   logic        wr32 = 1'b0;
   logic [31:0] wdata32 = '0;
   logic        ret32 = 1'b0;
   logic [31:0] rdata32;
   logic        perm32;

   logic [11:0] addr64 = 12'h000;
   logic        wr64 = 1'b0;
   logic [63:0] wdata64 = '0;
   logic        ret64 = 1'b0;
   logic [63:0] rdata64;
   logic        perm64;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   typedef struct {
      bit          d64;
      logic [63:0] data;
      bit          perm;
      string       req;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   ctr_gate #(.XLEN(32)) dut (
      .clk(clk), .rst_n(rst_n), .priv_i(priv32), .csr_addr_i(addr32),
      .csr_wr_i(wr32), .csr_wdata_i(wdata32), .retire_i(ret32),
      .rdata_o(rdata32), .permit_o(perm32)
   );

   ctr_gate #(.XLEN(64)) dut64 (
      .clk(clk), .rst_n(rst_n), .priv_i(M), .csr_addr_i(addr64),
      .csr_wr_i(wr64), .csr_wdata_i(wdata64), .retire_i(ret64),
      .rdata_o(rdata64), .permit_o(perm64)
   );

   task automatic rd(input logic [1:0] p, input logic [11:0] a,
                     input logic [63:0] d, input bit pm, input string r);
      @(negedge clk);
      priv32 = p; addr32 = a; wr32 = 1'b0; ret32 = 1'b0;
      sb.push_back('{1'b0, d, pm, r});
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit ret);
      @(negedge clk);
      addr32 = a; wdata32 = d; wr32 = 1'b1; ret32 = ret;
   endtask

   task automatic retire(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         addr32 = 12'h123; wr32 = 1'b0; ret32 = 1'b1;
      end
   endtask

   task automatic rd64(input logic [11:0] a, input logic [63:0] d,
                       input bit pm, input string r);
      @(negedge clk);
      addr64 = a; wr64 = 1'b0; ret64 = 1'b0;
      sb.push_back('{1'b1, d, pm, r});
   endtask

   task automatic wr64t(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      addr64 = a; wdata64 = d; wr64 = 1'b1; ret64 = 1'b0;
   endtask

   task automatic retire64(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         addr64 = 12'h123; wr64 = 1'b0; ret64 = 1'b1;
      end
   endtask

   // monitor: compare each scored access one ns after it is driven
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            logic [63:0] got;
            bit gp;
            e = sb.pop_front();
            got = e.d64 ? rdata64 : {32'h0, rdata32};
            gp  = e.d64 ? perm64 : perm32;
            checks++;
            if (got !== e.data || gp !== e.perm) begin
               fails++;
               $display("FAIL %s: data %h permit %0b, expected data %h permit %0b",
                        e.req, got, gp, e.data, e.perm);
            end
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(M, 12'hB00, 64'h0, 1'b1, "R10");
      rd(M, 12'h320, 64'h0, 1'b1, "R10");
      rd(M, 12'h321, 64'h0, 1'b1, "R10");
      rd64(12'hB00, 64'h0, 1'b1, "R10");

      // R9 increment, R3 shared counter
      retire(5);
      rd(M, 12'hB00, 64'd5, 1'b1, "R9");
      rd(M, 12'hB02, 64'd5, 1'b1, "R3");

      // R6 low write then carry into the upper half (R9)
      wr(12'hB00, 32'hFFFF_FFFE, 1'b0);
      retire(3);
      rd(M, 12'hB00, 64'd1, 1'b1, "R9");
      rd(M, 12'hB80, 64'd1, 1'b1, "R6");
      rd(M, 12'hB82, 64'd1, 1'b1, "R6");

      // R6 high write keeps low half, low write keeps high half
      wr(12'hB80, 32'h0000_ABCD, 1'b0);
      rd(M, 12'hB00, 64'd1, 1'b1, "R6");
      rd(M, 12'hB80, 64'hABCD, 1'b1, "R6");
      wr(12'hB02, 32'h10, 1'b0);
      rd(M, 12'hB80, 64'hABCD, 1'b1, "R6");
      rd(M, 12'hB00, 64'h10, 1'b1, "R6");

      // R9 write wins over a same-cycle retire
      wr(12'hB00, 32'd100, 1'b1);
      rd(M, 12'hB00, 64'd100, 1'b1, "R9");

      // R11 writes to read-only or zero addresses are ignored
      wr(12'hC00, 32'd7, 1'b0);
      wr(12'hB05, 32'd9, 1'b0);
      wr(12'h323, 32'd5, 1'b0);
      rd(M, 12'hB00, 64'd100, 1'b1, "R11");
      rd(M, 12'hB80, 64'hABCD, 1'b1, "R11");
      rd(M, 12'hB05, 64'h0, 1'b1, "R11");
      rd(M, 12'h323, 64'h0, 1'b1, "R11");

      // R8 full-value enable registers
      wr(12'h320, 32'h8000_0005, 1'b0);
      wr(12'h321, 32'h0000_0008, 1'b0);
      rd(M, 12'h320, 64'h8000_0005, 1'b1, "R8");
      rd(U, 12'h320, 64'h8000_0005, 1'b1, "R8");
      rd(S, 12'h321, 64'h8, 1'b1, "R8");

      // R1/R2 user mask
      rd(U, 12'hC00, 64'd100, 1'b1, "R1");
      rd(U, 12'hC02, 64'd100, 1'b1, "R3");
      rd(U, 12'hC03, 64'h0, 1'b0, "R2");
      rd(U, 12'hC1F, 64'h0, 1'b1, "R4");
      rd(U, 12'hC9F, 64'h0, 1'b1, "R4");

      // R1 supervisor mask
      rd(S, 12'hC03, 64'h0, 1'b1, "R4");
      rd(S, 12'hC00, 64'h0, 1'b0, "R1");
      rd(S, 12'hC02, 64'h0, 1'b0, "R1");

      // R1 machine: all allowed
      rd(M, 12'hC00, 64'd100, 1'b1, "R1");
      rd(M, 12'hC83, 64'h0, 1'b1, "R4");
      rd(M, 12'hC01, 64'h0, 1'b0, "R3");
      rd(M, 12'h322, 64'h0, 1'b0, "R3");
      rd(M, 12'h123, 64'h0, 1'b0, "R3");

      // R5 zero ranges
      rd(M, 12'hB1F, 64'h0, 1'b1, "R5");
      rd(M, 12'h33F, 64'h0, 1'b1, "R5");
      rd(M, 12'hB85, 64'h0, 1'b1, "R5");
      rd(U, 12'hB03, 64'h0, 1'b1, "R5");

      // R2 cleared mask denies
      wr(12'h320, 32'h0, 1'b0);
      rd(U, 12'hC00, 64'h0, 1'b0, "R2");

      // R7 64-bit variant
      wr64t(12'hB00, 64'h1234_5678_9ABC_DEF0);
      rd64(12'hB00, 64'h1234_5678_9ABC_DEF0, 1'b1, "R7");
      retire64(2);
      rd64(12'hB02, 64'h1234_5678_9ABC_DEF2, 1'b1, "R7");
      rd64(12'hB80, 64'h0, 1'b0, "R7");
      wr64t(12'hB80, 64'd5);
      rd64(12'hB00, 64'h1234_5678_9ABC_DEF2, 1'b1, "R7");

      repeat (4) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule